// File: doc/BRIEF.md
# Cache Line Prefetch Controller

This block decides when and where a set-associative cache should fetch a line ahead of demand. It watches the stream of lookup results (address plus hit or miss) from the cache. When an event matches the chosen trigger kind and falls inside one of two software-defined address windows, it requests the neighbouring line, one line above or below depending on a direction setting. Line size is selectable between 16 and 32 bytes. Fill requests leave on a valid/acknowledge handshake, and only one may be outstanding.

Software can also run a manual preload. It gives a start address, a byte size and a direction, and the block then requests every line that region touches, one after another. A done flag drops at the start and rises with the last request. Starting a preload turns automatic prefetch off and records whether it had been on. A separate suspend/resume pair does the same recording without a preload. Resume or end-of-preload turns automatic prefetch back on only when the restore value presented with it is 1.

The cache arrays, the refill datapath and external memory are outside this block.

Top module: `linePrefetchCtl`

## Requirements
- R1: After reset, reqValid is 0, preDone is 1, autoActive is 0 and wasAuto is 0.
- R2: An accepted event produces a request on the clock edge that samples it. The request address is the event address rounded down to a line boundary, plus one line when cfgStepDown is 0 or minus one line when it is 1. cfgLine32 = 0 selects 16-byte lines and 1 selects 32-byte lines.
- R3: cfgTrigMode 0 accepts misses only (evHit = 0), 1 accepts hits only, 2 accepts both, and 3 accepts none.
- R4: An event is used only when its address lies in [base, base + size) of an enabled window (cfgWinEn bit 0 for window 0, bit 1 for window 1). Window 0 is tested first, so when both windows match, window 0 is the triggering window.
- R5: A candidate line that falls outside the triggering window, or that wraps past either end of the address space, is dropped and produces no request.
- R6: Once raised, reqValid stays high with reqAddr unchanged until reqAck is sampled. Events that arrive while a request is outstanding are ignored. reqValid is low in the cycle after the acknowledge.
- R7: ctlEnable sets autoActive and ctlDisable clears it. While autoActive is 0, no event produces a request.
- R8: ctlSuspend copies autoActive into wasAuto and clears autoActive. ctlResume sets autoActive when ctlRestore is 1 and leaves it unchanged when ctlRestore is 0.
- R9: preStart copies autoActive into wasAuto, clears autoActive and clears preDone from the next cycle. It then requests every line from align(preBase) to align(preBase + preSize - 1), ascending when preDown is 0 and descending when it is 1. preDone rises together with the last request. A zero size issues no request, and preDone returns to 1 two cycles after the start.
- R10: preEnd stops a running preload (no further lines are requested), sets preDone, and restores autoActive in the same way as ctlResume.
- R11: When a preload line and an automatic prefetch are both ready in the same cycle, the preload line is issued and the automatic one is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgStepDown | input | 1 | Prefetch direction: 0 next higher line, 1 next lower line |
| cfgLine32 | input | 1 | Line size: 0 = 16 bytes, 1 = 32 bytes |
| cfgTrigMode | input | 2 | 0 miss, 1 hit, 2 both, 3 none |
| cfgWinEn | input | 2 | Per-window enable |
| cfgWinBase0 | input | ADDR_W | Window 0 start address |
| cfgWinSize0 | input | ADDR_W | Window 0 size in bytes |
| cfgWinBase1 | input | ADDR_W | Window 1 start address |
| cfgWinSize1 | input | ADDR_W | Window 1 size in bytes |
| evValid | input | 1 | Lookup event present |
| evHit | input | 1 | Lookup event was a hit |
| evAddr | input | ADDR_W | Lookup event address |
| ctlEnable | input | 1 | Pulse: turn automatic prefetch on |
| ctlDisable | input | 1 | Pulse: turn automatic prefetch off |
| ctlSuspend | input | 1 | Pulse: save state and hold off automatic prefetch |
| ctlResume | input | 1 | Pulse: restore according to ctlRestore |
| ctlRestore | input | 1 | Restore value used by ctlResume and preEnd |
| preStart | input | 1 | Pulse: start manual preload |
| preEnd | input | 1 | Pulse: end manual preload |
| preBase | input | ADDR_W | Preload start address |
| preSize | input | ADDR_W | Preload size in bytes (at most the cache capacity) |
| preDown | input | 1 | Preload order: 0 ascending, 1 descending |
| reqAck | input | 1 | Fill request accepted |
| reqValid | output | 1 | Fill request pending |
| reqAddr | output | ADDR_W | Line address of the fill request |
| autoActive | output | 1 | Automatic prefetch currently on |
| wasAuto | output | 1 | autoActive value saved by the last suspend or preload start |
| preDone | output | 1 | Manual preload finished |

## Verification
Every result appears one clock after the input that causes it, because every output is a register. An event or control pulse driven before edge N is visible at the sample after edge N. Preload lines follow at least two cycles apart, since the acknowledge edge blocks issue. The bench drives inputs on the falling edge and reads outputs on the next falling edge. For preloads it waits a bounded number of falling edges for each request rather than assuming a fixed spacing. The expected address, the expected presence or absence of a request, and the preDone value at each request are computed arithmetically from the window, line-size, direction and trigger settings.

// File: rtl/pf_pkg.sv
package pf_pkg;
  localparam int WIN_COUNT = 2;

  typedef enum logic [1:0] {
    TRIG_MISS = 2'd0,
    TRIG_HIT  = 2'd1,
    TRIG_ANY  = 2'd2,
    TRIG_OFF  = 2'd3
  } trigMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadMan;
    logic issueAuto;
    logic issueMan;
  } pfStrobe_t;
endpackage

// File: rtl/pf_datapath.sv
module pf_datapath
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  pfStrobe_t                        strb,
  input  logic                             cfgStepDown,
  input  logic                             cfgLine32,
  input  logic [WIN_COUNT-1:0]             cfgWinEn,
  input  logic [WIN_COUNT-1:0][ADDR_W-1:0] winBase,
  input  logic [WIN_COUNT-1:0][ADDR_W-1:0] winSize,
  input  logic [ADDR_W-1:0]                evAddr,
  input  logic [ADDR_W-1:0]                preBase,
  input  logic [ADDR_W-1:0]                preSize,
  input  logic                             preDown,
  output logic                             autoCand,
  output logic                             manPending,
  output logic                             manLast,
  output logic [ADDR_W-1:0]                reqAddr
);
  localparam int XW = ADDR_W + 1;

  logic [XW-1:0] lineBytes, lineMaskX, trigLine, nextAddr;
  logic [XW-1:0] startL, endL, manSpan, manCntLoad, manCnt, manAddr;
  logic          manDown;
  logic [WIN_COUNT-1:0] winHit, nextIn;

  function automatic logic inWindow(input logic [XW-1:0] a,
                                    input logic [ADDR_W-1:0] b,
                                    input logic [ADDR_W-1:0] s);
    logic [XW-1:0] off;
    off = a - {1'b0, b};
    return (a >= {1'b0, b}) && (off < {1'b0, s});
  endfunction

  assign lineBytes = cfgLine32 ? XW'(32) : XW'(16);
  assign lineMaskX = ~(lineBytes - XW'(1));
  assign trigLine  = {1'b0, evAddr} & lineMaskX;
  // top bit set means the step left the address space
  assign nextAddr  = cfgStepDown ? trigLine - lineBytes : trigLine + lineBytes;

  generate
    for (genvar w = 0; w < WIN_COUNT; w++) begin : gWin
      assign winHit[w] = cfgWinEn[w] && inWindow({1'b0, evAddr}, winBase[w], winSize[w]);
      assign nextIn[w] = inWindow(nextAddr, winBase[w], winSize[w]);
    end
  endgenerate

  // lowest-numbered matching window owns the event
  always_comb begin
    logic found;
    found    = 1'b0;
    autoCand = 1'b0;
    for (int w = 0; w < WIN_COUNT; w++) begin
      if (!found && winHit[w]) begin
        found    = 1'b1;
        autoCand = nextIn[w];
      end
    end
    autoCand = autoCand && !nextAddr[ADDR_W];
  end

  assign startL     = {1'b0, preBase} & lineMaskX;
  assign endL       = ({1'b0, preBase} + {1'b0, preSize} - XW'(1)) & lineMaskX;
  assign manSpan    = endL - startL;
  assign manCntLoad = (preSize == '0) ? '0
                    : ((cfgLine32 ? (manSpan >> 5) : (manSpan >> 4)) + XW'(1));

  assign manPending = (manCnt != '0);
  assign manLast    = (manCnt == XW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      manCnt  <= '0;
      manAddr <= '0;
      manDown <= 1'b0;
      reqAddr <= '0;
    end else begin
      if (strb.loadMan) begin
        manCnt  <= manCntLoad;
        manAddr <= preDown ? endL : startL;
        manDown <= preDown;
      end else if (strb.issueMan) begin
        manCnt  <= manCnt - XW'(1);
        manAddr <= manDown ? manAddr - lineBytes : manAddr + lineBytes;
      end
      if (strb.issueMan)
        reqAddr <= manAddr[ADDR_W-1:0];
      else if (strb.issueAuto)
        reqAddr <= nextAddr[ADDR_W-1:0];
    end
  end
endmodule

// File: rtl/pf_control.sv
module pf_control
  import pf_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       evValid,
  input  logic       evHit,
  input  logic [1:0] cfgTrigMode,
  input  logic       autoCand,
  input  logic       manPending,
  input  logic       manLast,
  input  logic       reqAck,
  input  logic       ctlEnable,
  input  logic       ctlDisable,
  input  logic       ctlSuspend,
  input  logic       ctlResume,
  input  logic       ctlRestore,
  input  logic       preStart,
  input  logic       preEnd,
  output pfStrobe_t  strb,
  output logic       reqValid,
  output logic       autoActive,
  output logic       wasAuto,
  output logic       preDone
);
  logic trigOk, manWant, autoWant, manRun;

  always_comb begin
    case (trigMode_e'(cfgTrigMode))
      TRIG_MISS: trigOk = !evHit;
      TRIG_HIT:  trigOk = evHit;
      TRIG_ANY:  trigOk = 1'b1;
      default:   trigOk = 1'b0;
    endcase
    manWant  = manRun && manPending && !reqValid && !preStart && !preEnd;
    autoWant = autoActive && evValid && trigOk && autoCand && !reqValid
               && !preStart && !manWant;
    strb.loadMan   = preStart;
    strb.issueMan  = manWant;
    strb.issueAuto = autoWant;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqValid   <= 1'b0;
      autoActive <= 1'b0;
      wasAuto    <= 1'b0;
      preDone    <= 1'b1;
      manRun     <= 1'b0;
    end else begin
      if (manWant || autoWant) reqValid <= 1'b1;
      else if (reqAck)         reqValid <= 1'b0;

      if (preStart || ctlSuspend) begin
        wasAuto    <= autoActive;
        autoActive <= 1'b0;
      end else if ((ctlResume || preEnd) && ctlRestore) begin
        autoActive <= 1'b1;
      end else if (ctlEnable) begin
        autoActive <= 1'b1;
      end else if (ctlDisable) begin
        autoActive <= 1'b0;
      end

      if (preStart) begin
        manRun  <= 1'b1;
        preDone <= 1'b0;
      end else if (preEnd) begin
        manRun  <= 1'b0;
        preDone <= 1'b1;
      end else if (manRun && (!manPending || (manWant && manLast))) begin
        manRun  <= 1'b0;
        preDone <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/linePrefetchCtl.sv
module linePrefetchCtl
  import pf_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgStepDown,
  input  logic              cfgLine32,
  input  logic [1:0]        cfgTrigMode,
  input  logic [1:0]        cfgWinEn,
  input  logic [ADDR_W-1:0] cfgWinBase0,
  input  logic [ADDR_W-1:0] cfgWinSize0,
  input  logic [ADDR_W-1:0] cfgWinBase1,
  input  logic [ADDR_W-1:0] cfgWinSize1,
  input  logic              evValid,
  input  logic              evHit,
  input  logic [ADDR_W-1:0] evAddr,
  input  logic              ctlEnable,
  input  logic              ctlDisable,
  input  logic              ctlSuspend,
  input  logic              ctlResume,
  input  logic              ctlRestore,
  input  logic              preStart,
  input  logic              preEnd,
  input  logic [ADDR_W-1:0] preBase,
  input  logic [ADDR_W-1:0] preSize,
  input  logic              preDown,
  input  logic              reqAck,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              autoActive,
  output logic              wasAuto,
  output logic              preDone
);
  pfStrobe_t strb;
  logic autoCand, manPending, manLast;
  logic [WIN_COUNT-1:0][ADDR_W-1:0] winBase, winSize;

  assign winBase = {cfgWinBase1, cfgWinBase0};
  assign winSize = {cfgWinSize1, cfgWinSize0};

  pf_datapath #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgStepDown(cfgStepDown), .cfgLine32(cfgLine32), .cfgWinEn(cfgWinEn),
    .winBase(winBase), .winSize(winSize), .evAddr(evAddr),
    .preBase(preBase), .preSize(preSize), .preDown(preDown),
    .autoCand(autoCand), .manPending(manPending), .manLast(manLast),
    .reqAddr(reqAddr)
  );

  pf_control uCtl (
    .clk(clk), .rstN(rstN), .evValid(evValid), .evHit(evHit),
    .cfgTrigMode(cfgTrigMode), .autoCand(autoCand), .manPending(manPending),
    .manLast(manLast), .reqAck(reqAck), .ctlEnable(ctlEnable),
    .ctlDisable(ctlDisable), .ctlSuspend(ctlSuspend), .ctlResume(ctlResume),
    .ctlRestore(ctlRestore), .preStart(preStart), .preEnd(preEnd),
    .strb(strb), .reqValid(reqValid), .autoActive(autoActive),
    .wasAuto(wasAuto), .preDone(preDone)
  );
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqAck,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              preStart,
  input logic              preEnd,
  input logic              ctlSuspend,
  input logic              autoActive,
  input logic              wasAuto,
  input logic              preDone
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqAck |=> reqValid && $stable(reqAddr));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqAck |=> !reqValid);

  assert_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> reqAddr[3:0] == 4'h0);

  assert_suspend_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctlSuspend |=> (wasAuto == $past(autoActive)) && !autoActive);

  assert_start_R9: assert property (@(posedge clk) disable iff (!rstN)
    preStart |=> !autoActive && !preDone);

  assert_end_R10: assert property (@(posedge clk) disable iff (!rstN)
    preEnd && !preStart |=> preDone);
endmodule

bind linePrefetchCtl pf_checker #(.ADDR_W(ADDR_W)) uCheck (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAck(reqAck),
  .reqAddr(reqAddr), .preStart(preStart), .preEnd(preEnd),
  .ctlSuspend(ctlSuspend), .autoActive(autoActive), .wasAuto(wasAuto),
  .preDone(preDone)
);

// File: tb/sim_linePrefetchCtl.sv
module sim_linePrefetchCtl;
  logic clk = 1'b0, rstN = 1'b0;
  logic cfgStepDown = 0, cfgLine32 = 0;
  logic [1:0] cfgTrigMode = 0, cfgWinEn = 0;
  logic [15:0] cfgWinBase0 = 0, cfgWinSize0 = 0, cfgWinBase1 = 0, cfgWinSize1 = 0;
  logic evValid = 0, evHit = 0;
  logic [15:0] evAddr = 0;
  logic ctlEnable = 0, ctlDisable = 0, ctlSuspend = 0, ctlResume = 0, ctlRestore = 0;
  logic preStart = 0, preEnd = 0, preDown = 0, reqAck = 0;
  logic [15:0] preBase = 0, preSize = 0;
  logic reqValid, autoActive, wasAuto, preDone;
  logic [15:0] reqAddr;

  int nChk = 0, nFail = 0;
  bit autoOn = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  linePrefetchCtl #(.ADDR_W(16)) u0 (.*);

  task automatic chk(input string r, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit expAuto(input int a, input bit hit, output int nxt);
    int lb, la, w, b, s;
    bit trig;
    lb = cfgLine32 ? 32 : 16;
    la = a & ~(lb - 1);
    trig = (cfgTrigMode == 0) ? !hit : (cfgTrigMode == 1) ? hit : (cfgTrigMode == 2);
    nxt = 0;
    if (!trig || !autoOn) return 0;
    if (cfgWinEn[0] && a >= int'(cfgWinBase0) && a < int'(cfgWinBase0) + int'(cfgWinSize0)) w = 0;
    else if (cfgWinEn[1] && a >= int'(cfgWinBase1) && a < int'(cfgWinBase1) + int'(cfgWinSize1)) w = 1;
    else return 0;
    b = (w == 0) ? int'(cfgWinBase0) : int'(cfgWinBase1);
    s = (w == 0) ? int'(cfgWinSize0) : int'(cfgWinSize1);
    nxt = cfgStepDown ? la - lb : la + lb;
    if (nxt < 0 || nxt > 65535) return 0;
    return (nxt >= b) && (nxt < b + s);
  endfunction

  task automatic evt(input int a, input bit hit, input string r);
    int nx;
    bit e;
    e = expAuto(a, hit, nx);
    evAddr = 16'(a); evHit = hit; evValid = 1;
    @(negedge clk);
    evValid = 0;
    chk(r, int'(reqValid), int'(e));
    if (e) chk(r, int'(reqAddr), nx);
    if (reqValid) begin
      reqAck = 1; @(negedge clk); reqAck = 0;
    end
  endtask

  task automatic manual(input int base, input int size, input bit down);
    int lb, first, last, cnt;
    lb = cfgLine32 ? 32 : 16;
    first = base & ~(lb - 1);
    last = (base + size - 1) & ~(lb - 1);
    cnt = (size == 0) ? 0 : (last - first) / lb + 1;
    preBase = 16'(base); preSize = 16'(size); preDown = down; preStart = 1;
    @(negedge clk);
    preStart = 0;
    chk("R9 done low after start", int'(preDone), 0);
    chk("R9 auto off during preload", int'(autoActive), 0);
    for (int k = 0; k < cnt; k++) begin
      int g = 0;
      while (!reqValid && g < 8) begin @(negedge clk); g++; end
      chk("R9 preload line address", int'(reqAddr), down ? last - k * lb : first + k * lb);
      chk("R9 done with last line", int'(preDone), int'(k == cnt - 1));
      reqAck = 1; @(negedge clk); reqAck = 0;
    end
    repeat (3) begin
      @(negedge clk);
      chk("R9 no extra preload line", int'(reqValid), 0);
    end
    chk("R9 done at end", int'(preDone), 1);
  endtask

  initial begin
    int addrs[13] = '{16'h0000, 16'h0007, 16'h0100, 16'h0210, 16'h022f, 16'h0230,
                      16'h0400, 16'hff00, 16'hff3c, 16'hffe0, 16'hfff0, 16'hffff, 16'h8000};
    repeat (3) @(negedge clk);
    chk("R1 reqValid", int'(reqValid), 0);
    chk("R1 preDone", int'(preDone), 1);
    chk("R1 autoActive", int'(autoActive), 0);
    chk("R1 wasAuto", int'(wasAuto), 0);
    rstN = 1;
    @(negedge clk);

    cfgWinEn = 2'b11;
    cfgWinBase0 = 16'h0000; cfgWinSize0 = 16'h0230;
    cfgWinBase1 = 16'hff00; cfgWinSize1 = 16'h0100;

    // R7: disabled means no requests
    cfgTrigMode = 2; autoOn = 0;
    evt(16'h0100, 0, "R7 off");
    ctlEnable = 1; @(negedge clk); ctlEnable = 0; autoOn = 1;
    chk("R7 enable", int'(autoActive), 1);

    // sweep: R2 R3 R4 R5
    for (int ln = 0; ln < 2; ln++)
      for (int dn = 0; dn < 2; dn++)
        for (int md = 0; md < 4; md++)
          for (int h = 0; h < 2; h++)
            foreach (addrs[i]) begin
              cfgLine32 = ln[0]; cfgStepDown = dn[0]; cfgTrigMode = md[1:0];
              evt(addrs[i], h[0], "R2 R3 R4 R5 sweep");
            end

    // R4 window priority and enable
    cfgLine32 = 0; cfgStepDown = 0; cfgTrigMode = 2;
    cfgWinBase0 = 16'h0100; cfgWinSize0 = 16'h0020;
    cfgWinBase1 = 16'h0000; cfgWinSize1 = 16'h1000;
    evt(16'h0110, 0, "R4 window0 first");
    evt(16'h0105, 0, "R4 window0 inside");
    cfgWinEn = 2'b10;
    evt(16'h0110, 0, "R4 window0 disabled");
    cfgWinEn = 2'b11;
    cfgWinBase0 = 16'h0000; cfgWinSize0 = 16'h0230;
    cfgWinBase1 = 16'hff00; cfgWinSize1 = 16'h0100;

    // R6 one outstanding
    evAddr = 16'h0100; evHit = 0; evValid = 1; @(negedge clk); evValid = 0;
    chk("R6 first request", int'(reqAddr), 16'h0110);
    evAddr = 16'h0040; evValid = 1; @(negedge clk); evValid = 0;
    chk("R6 still valid", int'(reqValid), 1);
    chk("R6 address held", int'(reqAddr), 16'h0110);
    @(negedge clk);
    chk("R6 held without ack", int'(reqValid), 1);
    reqAck = 1; @(negedge clk); reqAck = 0;
    chk("R6 low after ack", int'(reqValid), 0);

    // R7 disable
    ctlDisable = 1; @(negedge clk); ctlDisable = 0; autoOn = 0;
    chk("R7 disable", int'(autoActive), 0);
    evt(16'h0100, 0, "R7 disabled event");

    // R8 suspend / resume
    ctlEnable = 1; @(negedge clk); ctlEnable = 0; autoOn = 1;
    ctlSuspend = 1; @(negedge clk); ctlSuspend = 0; autoOn = 0;
    chk("R8 saved on", int'(wasAuto), 1);
    chk("R8 suspended", int'(autoActive), 0);
    evt(16'h0100, 0, "R8 suspended event");
    ctlResume = 1; ctlRestore = 0; @(negedge clk); ctlResume = 0;
    chk("R8 resume zero", int'(autoActive), 0);
    ctlSuspend = 1; @(negedge clk); ctlSuspend = 0;
    chk("R8 saved off", int'(wasAuto), 0);
    ctlResume = 1; ctlRestore = 1; @(negedge clk); ctlResume = 0; ctlRestore = 0; autoOn = 1;
    chk("R8 resume one", int'(autoActive), 1);
    evt(16'h0100, 0, "R8 resumed event");

    // R9 preload sweep
    for (int ln = 0; ln < 2; ln++)
      for (int dn = 0; dn < 2; dn++) begin
        cfgLine32 = ln[0];
        manual(16'h0100, 16'h0040, dn[0]);
        manual(16'h0108, 16'h0030, dn[0]);
        manual(16'h0000, 16'h0010, dn[0]);
        manual(16'h0ff8, 16'h0009, dn[0]);
        manual(16'h0200, 16'h0000, dn[0]);
      end
    cfgLine32 = 0;
    autoOn = 0;
    ctlEnable = 1; @(negedge clk); ctlEnable = 0;
    preBase = 16'h0300; preSize = 16'h0020; preDown = 0; preStart = 1;
    @(negedge clk); preStart = 0;
    chk("R9 saved auto", int'(wasAuto), 1);
    while (reqValid || !preDone) begin
      if (reqValid) reqAck = 1;
      @(negedge clk); reqAck = 0;
    end

    // R10 end stops preload
    ctlEnable = 1; @(negedge clk); ctlEnable = 0;
    preBase = 16'h0200; preSize = 16'h0100; preDown = 0; preStart = 1;
    @(negedge clk); preStart = 0;
    @(negedge clk);
    chk("R10 first line", int'(reqAddr), 16'h0200);
    reqAck = 1; preEnd = 1; ctlRestore = 1;
    @(negedge clk); reqAck = 0; preEnd = 0; ctlRestore = 0;
    chk("R10 done", int'(preDone), 1);
    chk("R10 restored", int'(autoActive), 1);
    repeat (3) begin
      @(negedge clk);
      chk("R10 stopped", int'(reqValid), 0);
    end

    // R11 preload beats auto
    preBase = 16'h0400; preSize = 16'h0020; preDown = 0; preStart = 1;
    @(negedge clk); preStart = 0;
    @(negedge clk);
    chk("R11 first line", int'(reqAddr), 16'h0400);
    reqAck = 1; ctlEnable = 1;
    @(negedge clk); reqAck = 0; ctlEnable = 0;
    chk("R11 auto back on", int'(autoActive), 1);
    evAddr = 16'h0100; evHit = 0; evValid = 1;
    @(negedge clk); evValid = 0;
    chk("R11 preload wins", int'(reqAddr), 16'h0410);
    chk("R11 done", int'(preDone), 1);
    reqAck = 1; @(negedge clk); reqAck = 0;
    autoOn = 1;
    evt(16'h0100, 0, "R11 auto after preload");

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChk++; nFail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end
endmodule